// File: doc/BRIEF.md
# DRAM Training Pattern Generator

This block sources the data words that a DRAM training engine writes to a memory data bus to stress it and train it. Software or a training sequencer selects a pattern family, the DQ bit that acts as the aggressor, whether the bus runs at full width or in 16-bit mode, and the burst length. It then pulses `start_i`. The block walks an internal word index from zero and presents one 32-bit word per beat on a valid/ready stream. Each word is computed on the fly from the running index. Depending on the family, the rules are odd/even inversion, phase windows of 4, 8, 16 or 32 words, and a swap of the active half-word in 16-bit mode.

Four families are supported: a crosstalk pattern in which the other lines toggle against the selected bit, a crosstalk-free single-bit pattern, an inter-symbol-interference pattern and a short test pattern. Any other type code streams zero words and raises an error flag. The flag stays high until the next accepted start.

Top module: `dram_pattern_streamer`

## Requirements
- R1: After a synchronous reset, `m_valid`, `m_last`, `busy_o` and `bad_type_o` are low.
- R2: A `start_i` pulse while `busy_o` is low latches the configuration. On the next cycle `m_valid` and `busy_o` are high and `m_data` holds the word for index 0. A `start_i` seen while `busy_o` is high is ignored.
- R3: The word index advances only on a beat where `m_valid` and `m_ready` are both high. While `m_valid` is high and `m_ready` is low, `m_data` and `m_last` hold their values. After a beat, the next cycle presents the word for the next index.
- R4: A burst carries `burst_len_i + 1` words, which allows 1 to 256 words. `m_last` is high only on the word whose index equals `burst_len_i`. When that word is accepted, `m_valid` and `busy_o` go low on the next cycle.
- R5: Type code 0 is the crosstalk pattern. Let B = 1 << `dq_sel_i`, inverted bitwise on odd indices. With `half_mode_i` = 0 (full width), B is placed in all four byte lanes. With `half_mode_i` = 1 (16-bit), B is placed in bytes 0–1 and ~B in bytes 2–3.
- R6: Type code 1 is the crosstalk-free pattern, with S = 1 << `dq_sel_i`. In full width, the word is S in all four byte lanes on even indices and zero on odd indices. In 16-bit mode, the word is S in bytes 2–3 on even indices and S in bytes 0–1 on odd indices; all other bytes are zero.
- R7: Type code 2 (ISI) in full width. Let p = index mod 32 and q = index mod 8. The base word is all ones when p > 15 and q is 5 or 7, or when p ≤ 15 and q = 6; otherwise it is zero. The base word is inverted when p mod 16 > 7.
- R8: Type code 2 (ISI) in 16-bit mode. Let p = index mod 16 and q = index mod 4. The base word is 0x0000FFFF when p > 7 and q > 1, 0xFFFF0000 when p ≤ 7 and q = 3, and zero otherwise. The base word is inverted when p mod 8 > 3.
- R9: Type code 3 is the test pattern. In full width, the word is zero for indices 2 to 5 and all ones otherwise. In 16-bit mode, the word is zero at indices 0 and 3 and all ones otherwise.
- R10: A type code from 4 to 15 streams all-zero words for the whole burst. `bad_type_o` is high from the first word of that burst until the next accepted start with a supported code.
- R11: Changes on `pat_type_i`, `dq_sel_i`, `half_mode_i` and `burst_len_i` during a burst have no effect on that burst's words or length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Starts a burst when the block is idle |
| pat_type_i | input | 4 | Pattern family code |
| dq_sel_i | input | 3 | DQ bit within a byte lane |
| half_mode_i | input | 1 | 0 = full-width bus, 1 = 16-bit bus |
| burst_len_i | input | 8 | Number of words in the burst minus one |
| m_valid | output | 1 | Output word valid |
| m_ready | input | 1 | Downstream accepts the word |
| m_data | output | 32 | Pattern word |
| m_last | output | 1 | Final word of the burst |
| busy_o | output | 1 | Burst in progress |
| bad_type_o | output | 1 | Last accepted start used an unsupported code |

## Verification
The hardest conditions to reach from the ports are the upper phase windows of the ISI family (indices 16 to 31 and the inversion beyond them) and the index wrap at a 256-word burst. These are reached only by long bursts. The bench therefore runs bursts of 40 to 256 words in both bus modes, with random back-pressure on `m_ready` so that index advance and stall hold are mixed. Configuration changes and repeated start pulses are injected in the middle of other bursts. The reference model keeps the configuration it latched, so any leak of the live inputs shows up as a data or length mismatch.

// File: rtl/trainpat_pkg.sv
package trainpat_pkg;

  typedef enum logic [3:0] {
    PK_XTALK = 4'd0,
    PK_QUIET = 4'd1,
    PK_ISI   = 4'd2,
    PK_TEST  = 4'd3
  } pat_kind_e;

  typedef struct packed {
    logic [3:0] kind;
    logic [2:0] bit_sel;
    logic       half;
  } burst_cfg_t;

  function automatic logic kind_supported(input logic [3:0] k);
    return (k == PK_XTALK) || (k == PK_QUIET) || (k == PK_ISI) || (k == PK_TEST);
  endfunction

endpackage

// File: rtl/trainpat_word_gen.sv
module trainpat_word_gen
  import trainpat_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 8
) (
  input  burst_cfg_t        cfg,
  input  logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] word,
  output logic              unsupported
);
  localparam int LANES = DATA_W / 8;
  localparam int HALF  = LANES / 2;

  logic [7:0] sel_byte;
  logic [7:0] xt_byte;
  logic       odd;
  logic       isi_full_bit;
  logic       isi_lo_bit;
  logic       isi_hi_bit;
  logic       test_full_bit;
  logic       test_half_bit;

  always_comb begin
    sel_byte = 8'd1 << cfg.bit_sel;
    odd      = idx[0];
    xt_byte  = odd ? ~sel_byte : sel_byte;
    // ISI, full width: 32-word cycle, 8-word phase
    if (idx[4]) isi_full_bit = (idx[2:0] == 3'd5) || (idx[2:0] == 3'd7);
    else        isi_full_bit = (idx[2:0] == 3'd6);
    isi_full_bit = isi_full_bit ^ idx[3];
    // ISI, 16-bit: 16-word cycle, 4-word phase
    isi_lo_bit = (idx[3] & idx[1]) ^ idx[2];
    isi_hi_bit = (~idx[3] & (idx[1:0] == 2'd3)) ^ idx[2];
    // test pattern
    test_full_bit = !((idx >= IDX_W'(2)) && (idx <= IDX_W'(5)));
    test_half_bit = !((idx == IDX_W'(0)) || (idx == IDX_W'(3)));
    unsupported   = !kind_supported(cfg.kind);
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam bit UPPER = (l >= HALF);
    always_comb begin
      word[8*l +: 8] = 8'h00;
      case (cfg.kind)
        PK_XTALK: begin
          if (cfg.half && UPPER) word[8*l +: 8] = ~xt_byte;
          else                   word[8*l +: 8] = xt_byte;
        end
        PK_QUIET: begin
          if (!cfg.half)  word[8*l +: 8] = odd ? 8'h00 : sel_byte;
          else if (UPPER) word[8*l +: 8] = odd ? 8'h00 : sel_byte;
          else            word[8*l +: 8] = odd ? sel_byte : 8'h00;
        end
        PK_ISI: begin
          if (!cfg.half)  word[8*l +: 8] = {8{isi_full_bit}};
          else if (UPPER) word[8*l +: 8] = {8{isi_hi_bit}};
          else            word[8*l +: 8] = {8{isi_lo_bit}};
        end
        PK_TEST: begin
          word[8*l +: 8] = cfg.half ? {8{test_half_bit}} : {8{test_full_bit}};
        end
        default: word[8*l +: 8] = 8'h00;
      endcase
    end
  end

endmodule

// File: rtl/trainpat_seq.sv
module trainpat_seq
  import trainpat_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  burst_cfg_t       cfg_in,
  input  logic [IDX_W-1:0] len_in,
  input  logic             ready,
  output logic             active,
  output logic             load,
  output burst_cfg_t       gen_cfg,
  output logic [IDX_W-1:0] gen_idx,
  output logic             gen_last
);
  burst_cfg_t       cfg_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] len_q;
  logic             start_acc;
  logic             beat;
  logic             done;

  always_comb begin
    start_acc = start_i && !active;
    beat      = active && ready;
    done      = beat && (idx_q == len_q);
    load      = start_acc || (beat && !done);
    gen_cfg   = start_acc ? cfg_in : cfg_q;
    gen_idx   = start_acc ? '0 : idx_q + IDX_W'(1);
    gen_last  = start_acc ? (len_in == '0) : (gen_idx == len_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      idx_q  <= '0;
      len_q  <= '0;
      cfg_q  <= '0;
    end else begin
      if (start_acc) begin
        active <= 1'b1;
        cfg_q  <= cfg_in;
        len_q  <= len_in;
        idx_q  <= '0;
      end else if (done) begin
        active <= 1'b0;
      end else if (beat) begin
        idx_q <= gen_idx;
      end
    end
  end

  // R3: index steps by exactly one on a non-final beat
  p_idx_step_r3: assert property (@(posedge clk) disable iff (rst)
    (active && ready && (idx_q != len_q)) |=> (idx_q == $past(idx_q) + IDX_W'(1)));

  // R11: latched length is stable for the whole burst
  p_len_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (active && !(ready && idx_q == len_q)) |=> $stable(len_q) && $stable(cfg_q));

endmodule

// File: rtl/dram_pattern_streamer.sv
module dram_pattern_streamer
  import trainpat_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [3:0]        pat_type_i,
  input  logic [2:0]        dq_sel_i,
  input  logic              half_mode_i,
  input  logic [IDX_W-1:0]  burst_len_i,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  output logic              m_last,
  output logic              busy_o,
  output logic              bad_type_o
);
  burst_cfg_t        cfg_in;
  burst_cfg_t        gen_cfg;
  logic [IDX_W-1:0]  gen_idx;
  logic              gen_last;
  logic              load;
  logic              active;
  logic [DATA_W-1:0] gen_word;
  logic              gen_bad;

  assign cfg_in = '{kind: pat_type_i, bit_sel: dq_sel_i, half: half_mode_i};

  trainpat_seq #(.IDX_W(IDX_W)) i_seq (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .cfg_in  (cfg_in),
    .len_in  (burst_len_i),
    .ready   (m_ready),
    .active  (active),
    .load    (load),
    .gen_cfg (gen_cfg),
    .gen_idx (gen_idx),
    .gen_last(gen_last)
  );

  trainpat_word_gen #(.DATA_W(DATA_W), .IDX_W(IDX_W)) i_gen (
    .cfg        (gen_cfg),
    .idx        (gen_idx),
    .word       (gen_word),
    .unsupported(gen_bad)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      m_data     <= '0;
      m_last     <= 1'b0;
      bad_type_o <= 1'b0;
    end else begin
      if (load) begin
        m_data <= gen_word;
        m_last <= gen_last;
      end else if (!active) begin
        m_last <= 1'b0;
      end
      if (start_i && !active) bad_type_o <= gen_bad;
    end
  end

  assign m_valid = active;
  assign busy_o  = active;

  // R3: stalled word holds
  p_stall_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last)));

  // R4: stream ends after the final word is accepted
  p_last_drop_r4: assert property (@(posedge clk) disable iff (rst)
    (m_valid && m_ready && m_last) |=> !m_valid);

  // R10: unsupported code yields zero words
  p_bad_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (m_valid && bad_type_o) |-> (m_data == '0));

  // R2: a burst opens only after a start request
  p_open_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(m_valid) |-> $past(start_i));

endmodule

// File: tb/test_dram_pattern_streamer.sv
module test_dram_pattern_streamer;
  logic        clk = 0;
  logic        rst;
  logic        start_i;
  logic [3:0]  pat_type_i;
  logic [2:0]  dq_sel_i;
  logic        half_mode_i;
  logic [7:0]  burst_len_i;
  logic        m_valid;
  logic        m_ready;
  logic [31:0] m_data;
  logic        m_last;
  logic        busy_o;
  logic        bad_type_o;

  always #2.5 clk = ~clk;

  dram_pattern_streamer i_dram_pattern_streamer (.*);

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  bit checking = 0;
  bit disturbing = 0;
  bit stalling = 0;

  // reference model state
  bit m_busy = 0;
  bit m_err  = 0;
  int m_idx, m_len, m_kind, m_bit;
  bit m_half;

  function automatic logic [31:0] ref_word(int kind, int b, bit half, int idx);
    logic [7:0] by;
    int p, q;
    logic [31:0] w;
    by = 8'(1 << b);
    case (kind)
      0: begin
        if (idx % 2 == 1) by = ~by;
        if (half) return {~by, ~by, by, by};
        return {by, by, by, by};
      end
      1: begin
        if (!half) return (idx % 2 == 0) ? {by, by, by, by} : 32'h0;
        return (idx % 2 == 0) ? {by, by, 16'h0} : {16'h0, by, by};
      end
      2: begin
        if (!half) begin
          p = idx % 32; q = idx % 8;
          if (p > 15) w = (q == 5 || q == 7) ? 32'hFFFFFFFF : 32'h0;
          else        w = (q == 6) ? 32'hFFFFFFFF : 32'h0;
          if (p % 16 > 7) w = ~w;
        end else begin
          p = idx % 16; q = idx % 4;
          if (p > 7) w = (q > 1) ? 32'h0000FFFF : 32'h0;
          else       w = (q == 3) ? 32'hFFFF0000 : 32'h0;
          if (p % 8 > 3) w = ~w;
        end
        return w;
      end
      3: begin
        if (!half) return (idx >= 2 && idx <= 5) ? 32'h0 : 32'hFFFFFFFF;
        return (idx == 0 || idx == 3) ? 32'h0 : 32'hFFFFFFFF;
      end
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of();
    string t;
    case (m_kind)
      0: t = "R5";
      1: t = "R6";
      2: t = m_half ? "R8" : "R7";
      3: t = "R9";
      default: t = "R10";
    endcase
    if (stalling)   t = {t, "/R3"};
    if (disturbing) t = {t, "/R11"};
    return t;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_busy = 0; m_err = 0;
    end else if (m_busy) begin
      if (m_ready) begin
        if (m_idx == m_len) m_busy = 0;
        else m_idx++;
      end
    end else if (start_i) begin
      m_busy = 1; m_idx = 0;
      m_len = int'(burst_len_i); m_kind = int'(pat_type_i);
      m_bit = int'(dq_sel_i); m_half = half_mode_i;
      m_err = (m_kind > 3);
    end
  end

  always @(negedge clk) begin
    if (checking) begin
      logic [31:0] exp_d;
      vectors++;
      if (m_valid !== m_busy || busy_o !== m_busy) begin
        errors++;
        $display("FAIL R2/R4 valid=%b busy=%b expected %b (cycle %0d)", m_valid, busy_o, m_busy, cycles);
      end
      if (bad_type_o !== m_err) begin
        errors++;
        $display("FAIL R10 bad_type=%b expected %b", bad_type_o, m_err);
      end
      if (m_busy) begin
        exp_d = ref_word(m_kind, m_bit, m_half, m_idx);
        if (m_data !== exp_d) begin
          errors++;
          $display("FAIL %s idx=%0d data=%h expected %h", tag_of(), m_idx, m_data, exp_d);
        end
        if (m_last !== (m_idx == m_len)) begin
          errors++;
          $display("FAIL R4 idx=%0d last=%b expected %b", m_idx, m_last, (m_idx == m_len));
        end
      end
    end
  end

  task automatic run_burst(int kind, int b, bit half, int len, bit stall, bit disturb);
    @(negedge clk);
    pat_type_i = 4'(kind); dq_sel_i = 3'(b); half_mode_i = half; burst_len_i = 8'(len);
    start_i = 1; stalling = stall; disturbing = disturb;
    m_ready = stall ? ($urandom % 3 != 0) : 1'b1;
    @(negedge clk);
    start_i = 0;
    while (m_busy) begin
      m_ready = stall ? ($urandom % 3 != 0) : 1'b1;
      if (disturb) begin
        pat_type_i = 4'($urandom); dq_sel_i = 3'($urandom);
        half_mode_i = 1'($urandom); burst_len_i = 8'($urandom);
        start_i = 1'($urandom);
      end
      @(negedge clk);
    end
    start_i = 0; m_ready = 1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    rst = 1; start_i = 0; pat_type_i = 0; dq_sel_i = 0; half_mode_i = 0;
    burst_len_i = 0; m_ready = 1;
    repeat (3) @(negedge clk);
    vectors++;
    if (m_valid !== 0 || m_last !== 0 || busy_o !== 0 || bad_type_o !== 0) begin
      errors++;
      $display("FAIL R1 reset outputs v=%b l=%b b=%b e=%b expected 0000", m_valid, m_last, busy_o, bad_type_o);
    end
    rst = 0;
    checking = 1;
    @(negedge clk);
    for (int h = 0; h < 2; h++) begin
      run_burst(0, 3, h[0], 9, 0, 0);      // R5
      run_burst(1, 6, h[0], 9, 1, 0);      // R6
      run_burst(2, 0, h[0], 69, 0, 0);     // R7 / R8
      run_burst(2, 0, h[0], 69, 1, 0);
      run_burst(3, 1, h[0], 7, 0, 0);      // R9
      run_burst(0, 7, h[0], 0, 0, 0);      // R4 single word
    end
    run_burst(9, 2, 0, 5, 1, 0);           // R10
    run_burst(15, 2, 1, 3, 0, 0);          // R10
    run_burst(1, 4, 0, 3, 0, 0);           // R10 flag clears
    for (int k = 0; k < 4; k++) run_burst(k, k + 2, k[0], 40, 1, 1); // R11, R2 ignored starts
    run_burst(2, 5, 0, 255, 1, 0);         // R4 256-word burst, index wrap
    run_burst(0, 1, 1, 255, 0, 1);
    checking = 0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    errors++;
    $display("FAIL watchdog expired at cycle %0d, expected completion", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule